// File: doc/BRIEF.md
# Element-Size Packing Buffer for a DMA Channel

This block is the staging buffer placed between the source side and the destination side of one DMA channel. Source elements arrive 1, 2, 4 or 8 bytes wide through a read handshake. Destination elements leave 1, 2, 4 or 8 bytes wide through a write handshake. Bytes are packed or split in between as the two sizes require. The block holds at most 32 bytes, organised as four 64-bit words.

The block paces its own traffic in bursts. Each burst first collects a fixed number of source elements and then writes out everything it has gathered. The buffer is then empty for at least one cycle, and an outside arbiter may switch channels at that point. The burst length follows from the two element sizes and a bypass setting:

- In normal mode the burst length is the larger of four smaller elements and one larger element.
- In bypass mode the burst length is one larger element. This lets the arbiter step in after every source element, at the cost of more bus turnarounds.

A remaining-element count is loaded at start. When it reaches zero, the burst in progress is cut short and drained, and a one-cycle done pulse follows.

Top module: `dma_pack_fifo`

## Requirements
- R1: While and after a synchronous active-high reset, `rd_valid`, `wr_valid`, `full`, `done` and `busy` are low and `empty` is high.
- R2: Element sizes are coded 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. With bypass clear, a burst moves B = max(4·min(Rb,Wb), max(Rb,Wb)) bytes, and issues B/Rb source reads. The buffer never holds more than 32 bytes.
- R3: With bypass clear, a full burst issues B/Wb destination writes. Writes start only after the last read of the burst, and a read and a write are never requested in the same cycle.
- R4: With bypass set, a burst moves max(Rb,Wb) bytes, giving max(Rb,Wb)/Rb reads followed by max(Rb,Wb)/Wb writes.
- R5: Packing is little-endian. Byte k of the stream sits in lane k mod Wb of `wr_data`, where lane j is bits 8j+7..8j. The first stream byte is lane 0 of the first read. `rd_data` lanes at or above Rb are ignored, and `wr_data` lanes at or above Wb are zero.
- R6: `full` is high from the cycle after the last read of a burst until the buffer has drained. `rd_valid` is never high while `full` is high.
- R7: `empty` is high exactly when no byte is held. Between two bursts there is at least one cycle with `empty` high and neither request valid.
- R8: Once the remaining count reaches zero, no further reads are issued and the held bytes are written out. A final write holding fewer than Wb bytes is zero-padded. `done` pulses for one cycle once the buffer is empty.
- R9: `start` is ignored while `busy` is high. A start with a count of zero issues no reads and pulses `done` in the following cycle.
- R10: A request held back by a low ready keeps its valid asserted. A stalled write also keeps `wr_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a channel transfer using the cfg_* values |
| cfg_rsize | input | 2 | Source element size code |
| cfg_wsize | input | 2 | Destination element size code |
| cfg_bypass | input | 1 | Limit buffering to one element |
| cfg_count | input | CNT_W | Number of source elements to move |
| rd_valid | output | 1 | Source read request |
| rd_ready | input | 1 | Source accepts the read; rd_data is valid |
| rd_data | input | 64 | Source element, low lanes used |
| wr_valid | output | 1 | Destination write request |
| wr_ready | input | 1 | Destination accepts the write |
| wr_data | output | 64 | Destination element, low lanes used |
| empty | output | 1 | No byte held; arbitration point |
| full | output | 1 | Reads stopped, buffer draining |
| done | output | 1 | One-cycle pulse when the transfer has finished |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest condition to reach from the ports is a short final burst. The count must run out partway through a burst, and the bytes left over must not fill a whole destination element. That case requires a count that is not a multiple of the burst's read count, combined with a write size larger than the read size. The bench builds it with one-byte reads, four-byte writes and a count of six, so the second burst drains two bytes into a padded write. A second hard case is a start request arriving mid-transfer. The bench pulses start with a conflicting configuration while a stalled transfer is under way. It then checks that the data stream and the burst structure still match the first configuration.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;

    // Byte lanes of the widest element (64 bits).
    localparam int LANES = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_GAP   = 2'd3
    } dmaf_state_e;

    // Size code to byte count: 0->1, 1->2, 2->4, 3->8.
    function automatic logic [3:0] code_bytes(input logic [1:0] code);
        return 4'(1) << code;
    endfunction

endpackage

// File: rtl/dmaf_burst_calc.sv
module dmaf_burst_calc
    import dmaf_pkg::*;
#(
    parameter int MULT      = 4,
    parameter int CNT_OUT_W = 6,
    localparam int BW       = CNT_OUT_W + 4
) (
    input  logic [1:0]           rsz,
    input  logic [1:0]           wsz,
    input  logic                 byp,
    output logic [CNT_OUT_W-1:0] burst_reads
);

    logic [BW-1:0] rb;
    logic [BW-1:0] wb;
    logic [BW-1:0] small_b;
    logic [BW-1:0] large_b;
    logic [BW-1:0] multi_b;
    logic [BW-1:0] burst_b;

    always_comb begin
        rb      = BW'(code_bytes(rsz));
        wb      = BW'(code_bytes(wsz));
        small_b = (rb < wb) ? rb : wb;
        large_b = (rb < wb) ? wb : rb;
        multi_b = small_b * BW'(MULT);
        if (byp) begin
            burst_b = large_b;
        end else begin
            burst_b = (multi_b > large_b) ? multi_b : large_b;
        end
        burst_reads = CNT_OUT_W'(burst_b >> rsz);
    end

endmodule

// File: rtl/dmaf_byte_store.sv
module dmaf_byte_store #(
    parameter int DEPTH  = 32,
    parameter int LANES  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1),
    localparam int NW    = $clog2(LANES + 1),
    localparam int LIW   = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push_en,
    input  logic [NW-1:0]      push_n,
    input  logic [8*LANES-1:0] push_data,
    input  logic               pop_en,
    input  logic [NW-1:0]      pop_n,
    output logic [8*LANES-1:0] pop_data,
    output logic [LW-1:0]      level
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      wr_ptr;
        logic [PTR_W-1:0]      rd_ptr;
        logic [LW-1:0]         level;
    } store_t;

    store_t s_d, s_q;

    logic [LW-1:0]    put;
    logic [LW-1:0]    avail;
    logic [LW-1:0]    take;
    logic [PTR_W-1:0] off;
    logic [PTR_W-1:0] idx;

    always_comb begin
        s_d   = s_q;
        put   = push_en ? LW'(push_n) : '0;
        avail = (LW'(pop_n) < s_q.level) ? LW'(pop_n) : s_q.level;
        take  = pop_en ? avail : '0;
        off   = '0;
        idx   = '0;

        // Write the incoming bytes at the write pointer, wrapping around.
        for (int i = 0; i < DEPTH; i++) begin
            off = PTR_W'(i) - s_q.wr_ptr;
            if (push_en && (LW'(off) < put)) begin
                s_d.mem[i] = push_data[8*off[LIW-1:0] +: 8];
            end
        end

        // Present the oldest bytes; lanes past what is held are zero.
        for (int k = 0; k < LANES; k++) begin
            idx = s_q.rd_ptr + PTR_W'(k);
            pop_data[8*k +: 8] = (LW'(k) < avail) ? s_q.mem[idx] : 8'h00;
        end

        s_d.wr_ptr = s_q.wr_ptr + PTR_W'(put);
        s_d.rd_ptr = s_q.rd_ptr + PTR_W'(take);
        s_d.level  = s_q.level + put - take;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level = s_q.level;

endmodule

// File: rtl/dmaf_ctrl.sv
module dmaf_ctrl
    import dmaf_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LW    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       cfg_rsize,
    input  logic [1:0]       cfg_wsize,
    input  logic             cfg_bypass,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [LW-1:0]    burst_reads,
    input  logic [LW-1:0]    level,
    input  logic             rd_ready,
    input  logic             wr_ready,
    output logic             rd_valid,
    output logic             wr_valid,
    output logic             push_en,
    output logic             pop_en,
    output logic             full,
    output logic             done,
    output logic             busy,
    output logic [1:0]       rsz,
    output logic [1:0]       wsz,
    output logic             byp
);

    typedef struct packed {
        dmaf_state_e      st;
        logic [1:0]       rsz;
        logic [1:0]       wsz;
        logic             byp;
        logic [CNT_W-1:0] remain;
        logic [LW-1:0]    rd_cnt;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [LW-1:0] wr_bytes;

    always_comb begin
        c_d      = c_q;
        wr_bytes = LW'(code_bytes(c_q.wsz));
        rd_valid = (c_q.st == ST_READ);
        wr_valid = (c_q.st == ST_WRITE);
        push_en  = rd_valid && rd_ready;
        pop_en   = wr_valid && wr_ready;
        full     = (c_q.st == ST_WRITE);
        done     = (c_q.st == ST_GAP) && (c_q.remain == '0);
        busy     = (c_q.st != ST_IDLE);

        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.rsz    = cfg_rsize;
                    c_d.wsz    = cfg_wsize;
                    c_d.byp    = cfg_bypass;
                    c_d.remain = cfg_count;
                    c_d.rd_cnt = '0;
                    c_d.st     = (cfg_count == '0) ? ST_GAP : ST_READ;
                end
            end
            ST_READ: begin
                if (push_en) begin
                    c_d.rd_cnt = c_q.rd_cnt + LW'(1);
                    c_d.remain = c_q.remain - CNT_W'(1);
                    if ((c_q.rd_cnt + LW'(1) == burst_reads) ||
                        (c_q.remain == CNT_W'(1))) begin
                        c_d.st = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (pop_en && (level <= wr_bytes)) begin
                    c_d.st = ST_GAP;
                end
            end
            ST_GAP: begin
                c_d.rd_cnt = '0;
                c_d.st     = (c_q.remain == '0) ? ST_IDLE : ST_READ;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rsz = c_q.rsz;
    assign wsz = c_q.wsz;
    assign byp = c_q.byp;

endmodule

// File: rtl/dma_pack_fifo.sv
module dma_pack_fifo
    import dmaf_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       cfg_rsize,
    input  logic [1:0]       cfg_wsize,
    input  logic             cfg_bypass,
    input  logic [CNT_W-1:0] cfg_count,
    output logic             rd_valid,
    input  logic             rd_ready,
    input  logic [63:0]      rd_data,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [63:0]      wr_data,
    output logic             empty,
    output logic             full,
    output logic             done,
    output logic             busy
);

    localparam int CAP_BYTES = ENTRIES * LANES;
    localparam int LVL_W     = $clog2(CAP_BYTES + 1);
    localparam int NW        = $clog2(LANES + 1);

    logic [1:0]       act_rsz;
    logic [1:0]       act_wsz;
    logic             act_byp;
    logic [LVL_W-1:0] burst_reads;
    logic [LVL_W-1:0] fill_level;
    logic             push_en;
    logic             pop_en;

    dmaf_burst_calc #(
        .MULT      (ENTRIES),
        .CNT_OUT_W (LVL_W)
    ) u_calc (
        .rsz         (act_rsz),
        .wsz         (act_wsz),
        .byp         (act_byp),
        .burst_reads (burst_reads)
    );

    dmaf_ctrl #(
        .CNT_W (CNT_W),
        .LW    (LVL_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cfg_rsize   (cfg_rsize),
        .cfg_wsize   (cfg_wsize),
        .cfg_bypass  (cfg_bypass),
        .cfg_count   (cfg_count),
        .burst_reads (burst_reads),
        .level       (fill_level),
        .rd_ready    (rd_ready),
        .wr_ready    (wr_ready),
        .rd_valid    (rd_valid),
        .wr_valid    (wr_valid),
        .push_en     (push_en),
        .pop_en      (pop_en),
        .full        (full),
        .done        (done),
        .busy        (busy),
        .rsz         (act_rsz),
        .wsz         (act_wsz),
        .byp         (act_byp)
    );

    dmaf_byte_store #(
        .DEPTH (CAP_BYTES),
        .LANES (LANES)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .push_en   (push_en),
        .push_n    (NW'(code_bytes(act_rsz))),
        .push_data (rd_data),
        .pop_en    (pop_en),
        .pop_n     (NW'(code_bytes(act_wsz))),
        .pop_data  (wr_data),
        .level     (fill_level)
    );

    assign empty = (fill_level == '0);

endmodule

// File: rtl/dmaf_checker.sv
module dmaf_checker #(
    parameter int CAP = 32,
    parameter int LW  = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [63:0]   wr_data,
    input logic          full,
    input logic          done,
    input logic          empty,
    input logic          busy,
    input logic [LW-1:0] level
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(CAP)); // R2

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && wr_valid)); // R3

    AST_NO_READ_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        full |-> !rd_valid); // R6

    AST_DRAINED_AT_FULL_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(full) |-> empty); // R6

    AST_WRITE_HAS_BYTES: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !empty); // R7

    AST_DONE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        done |-> (empty && busy && !rd_valid && !wr_valid)); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> rd_valid); // R10

    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data))); // R10

endmodule

bind dma_pack_fifo dmaf_checker #(
    .CAP (CAP_BYTES),
    .LW  (LVL_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_data  (wr_data),
    .full     (full),
    .done     (done),
    .empty    (empty),
    .busy     (busy),
    .level    (fill_level)
);

// File: tb/tb_dma_pack_fifo.sv
module tb_dma_pack_fifo;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [1:0]       cfg_rsize = 2'd0;
    logic [1:0]       cfg_wsize = 2'd0;
    logic             cfg_bypass = 1'b0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic             rd_valid;
    logic             rd_ready = 1'b0;
    logic [63:0]      rd_data = '0;
    logic             wr_valid;
    logic             wr_ready = 1'b0;
    logic [63:0]      wr_data;
    logic             empty, full, done, busy;

    always #10 clk = ~clk;

    dma_pack_fifo #(.ENTRIES(4), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_rsize(cfg_rsize), .cfg_wsize(cfg_wsize),
        .cfg_bypass(cfg_bypass), .cfg_count(cfg_count),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .empty(empty), .full(full), .done(done), .busy(busy)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int seed   = 0;
    int cur_rb = 1;
    int src_idx = 0;
    int b_reads = 0;
    int b_writes = 0;
    int tot_reads = 0;
    int done_seen = 0;
    bit stall_mode = 1'b0;
    bit cur_byp = 1'b0;
    bit prev_wstall = 1'b0;
    logic [63:0] prev_wdata = '0;
    logic [63:0] ev;
    int er, ew;

    logic [63:0] exp_wr_q[$];
    int          exp_rd_q[$];
    int          exp_bw_q[$];

    function automatic logic [7:0] src_byte(input int s, input int k);
        return 8'(s * 31 + k * 7 + 3);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Source/destination model and scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R8 watchdog: actual cycle %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
        if (!rst) begin
            rd_ready = !(stall_mode && (cyc % 3 == 0));
            wr_ready = !(stall_mode && (cyc % 4 == 1));
            for (int k = 0; k < 8; k++) begin
                rd_data[8*k +: 8] = (k < cur_rb) ? src_byte(seed, src_idx * cur_rb + k) : 8'hEE;
            end
            if (rd_valid) check(!full, "R6", "read while full", 64'(full), 64'd0);
            if (wr_valid) check(full, "R6", "full during drain", 64'(full), 64'd1);
            if (wr_valid) check(!empty, "R7", "empty while holding", 64'(empty), 64'd0);
            if (prev_wstall)
                check(wr_valid && (wr_data == prev_wdata), "R10", "stalled write",
                      wr_data, prev_wdata);
            prev_wstall = wr_valid && !wr_ready;
            prev_wdata  = wr_data;
            if (rd_valid && rd_ready) begin
                src_idx++;
                b_reads++;
                tot_reads++;
            end
            if (wr_valid && wr_ready) begin
                b_writes++;
                if (exp_wr_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected write", wr_data, 64'd0);
                end else begin
                    ev = exp_wr_q.pop_front();
                    check(wr_data == ev, "R5", "write data", wr_data, ev);
                end
            end
            if (empty && !rd_valid && !wr_valid && (b_reads > 0)) begin
                if (exp_rd_q.size() == 0) begin
                    check(1'b0, cur_byp ? "R4" : "R2", "unexpected burst", 64'(b_reads), 64'd0);
                end else begin
                    er = exp_rd_q.pop_front();
                    ew = exp_bw_q.pop_front();
                    check(b_reads == er, cur_byp ? "R4" : "R2", "reads per burst",
                          64'(b_reads), 64'(er));
                    check(b_writes == ew, cur_byp ? "R4" : "R3", "writes per burst",
                          64'(b_writes), 64'(ew));
                end
                b_reads  = 0;
                b_writes = 0;
            end
            if (done) begin
                done_seen++;
                check(empty, "R8", "empty at done", 64'(empty), 64'd1);
            end
        end
    end

    // Driver: predicts bursts and write words, then runs one channel
    task automatic run_chan(input int r, input int w, input bit byp, input int cnt,
                            input bit stl, input bit inject);
        int rb, wb, mn, mx, bb, rem, n, tot, t;
        logic [63:0] word;
        rb  = 1 << r;
        wb  = 1 << w;
        mn  = (rb < wb) ? rb : wb;
        mx  = (rb < wb) ? wb : rb;
        bb  = byp ? mx : ((4 * mn > mx) ? 4 * mn : mx);
        seed = seed + 1;
        cur_rb = rb;
        src_idx = 0;
        stall_mode = stl;
        cur_byp = byp;
        tot_reads = 0;
        done_seen = 0;
        rem = cnt;
        while (rem > 0) begin
            n = (bb / rb < rem) ? bb / rb : rem;
            exp_rd_q.push_back(n);
            exp_bw_q.push_back((n * rb + wb - 1) / wb);
            rem -= n;
        end
        tot = cnt * rb;
        for (int j = 0; j * wb < tot; j++) begin
            word = '0;
            for (int k = 0; k < wb; k++) begin
                if (j * wb + k < tot) word[8*k +: 8] = src_byte(seed, j * wb + k);
            end
            exp_wr_q.push_back(word);
        end
        @(negedge clk); #2;
        start = 1'b1;
        cfg_rsize = 2'(r);
        cfg_wsize = 2'(w);
        cfg_bypass = byp;
        cfg_count = CNT_W'(cnt);
        @(negedge clk); #2;
        start = 1'b0;
        if (cnt == 0) begin
            #1;
            check(done && !rd_valid, "R9", "zero-count done", 64'(done), 64'd1);
        end
        if (inject) begin
            repeat (3) @(negedge clk);
            #2;
            start = 1'b1;
            cfg_rsize = 2'd0;
            cfg_wsize = 2'd3;
            cfg_bypass = 1'b1;
            cfg_count = CNT_W'(50);
            @(negedge clk); #2;
            start = 1'b0;
        end
        t = 0;
        while (done_seen == 0 && t < 20000) begin
            @(negedge clk); #1;
            t++;
        end
        repeat (12) @(negedge clk);
        #1;
        check(done_seen == 1, "R8", "done pulses", 64'(done_seen), 64'd1);
        check(exp_wr_q.size() == 0, "R8", "writes left", 64'(exp_wr_q.size()), 64'd0);
        check(exp_rd_q.size() == 0, byp ? "R4" : "R2", "bursts left",
              64'(exp_rd_q.size()), 64'd0);
        check(tot_reads == cnt, inject ? "R9" : "R8", "total reads", 64'(tot_reads), 64'(cnt));
        check(!busy && empty, "R7", "idle and empty", {62'd0, busy, empty}, 64'd1);
        exp_wr_q.delete();
        exp_rd_q.delete();
        exp_bw_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!rd_valid && !wr_valid && !full && !done && !busy && empty, "R1",
              "state in reset", {58'd0, rd_valid, wr_valid, full, done, busy, empty}, 64'd1);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        check(!rd_valid && !wr_valid && !full && !done && !busy && empty, "R1",
              "state after reset", {58'd0, rd_valid, wr_valid, full, done, busy, empty}, 64'd1);

        run_chan(0, 0, 1'b0, 10, 1'b0, 1'b0); // R2 R3 equal sizes, short last burst
        run_chan(0, 3, 1'b0, 16, 1'b1, 1'b0); // R2 R5 8 byte reads into one write
        run_chan(3, 0, 1'b0, 3, 1'b1, 1'b1);  // R3 R9 R10 unpack, start during busy
        run_chan(3, 2, 1'b0, 4, 1'b0, 1'b0);  // R3 two reads, four writes
        run_chan(1, 0, 1'b0, 5, 1'b1, 1'b0);  // R3 R8 last burst of one read
        run_chan(2, 3, 1'b1, 4, 1'b0, 1'b0);  // R4 bypass packing
        run_chan(0, 0, 1'b1, 3, 1'b1, 1'b0);  // R4 bypass one to one
        run_chan(3, 0, 1'b1, 2, 1'b0, 1'b0);  // R4 bypass unpacking
        run_chan(0, 2, 1'b0, 6, 1'b0, 1'b0);  // R8 padded final write
        run_chan(2, 1, 1'b0, 0, 1'b0, 1'b0);  // R9 zero count

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule